// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a small binary counter, four bits wide by default, with two count strobes instead of an enable and a direction bit. A rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. Each strobe counts only while the other strobe rests high. A master clear forces the value to zero. An active-low load copies a data word into the counter. Clear takes precedence over load, and load takes precedence over counting.

Every input is sampled on one system clock. A strobe edge is a sample of 1 whose previous sample was 0. Clear and load act at the next system clock edge. The edge registers keep following their strobes while clear or load is held, so a strobe that is low through a clear or a load still counts when it next rises.

Two active-low terminal outputs copy the low phase of a strobe at the count limits. The up output is low while the value is at its maximum and the up strobe is low. The down output is low while the value is zero and the down strobe is low. Wiring these outputs to the strobes of a second instance builds a wider counter. Both stages then step on the same system clock edge. The block has no streaming data path, so every pin is a plain level.

Top module: `udc_counter`

## Requirements
- R1: A rising up strobe, sampled while the down strobe is high in both the current and the previous sample, adds one to the value at that clock edge. The value wraps from 15 to 0.
- R2: A rising down strobe, sampled while the up strobe is high in both the current and the previous sample, subtracts one from the value. The value wraps from 0 to 15.
- R3: If both strobes rise in the same sample, or neither strobe rises, the value does not change.
- R4: `clr` high sets the value to 0 at the next clock edge. This holds whatever the state of `load_n` and of both strobes.
- R5: `load_n` low with `clr` low places `din` on `q` at the next clock edge. This holds whatever the strobes do, and a strobe rising while load is held has no effect.
- R6: `up_tc_n` is low exactly when `q` is 15 and `up_stb` is low. It follows `up_stb` without a clock delay.
- R7: `dn_tc_n` is low exactly when `q` is 0 and `dn_stb` is low. It follows `dn_stb` without a clock delay.
- R8: A strobe held low through a clear or a load, and released afterwards, counts on its next rising edge.
- R9: Two instances, with the lower stage's `up_tc_n` driving the upper stage's `up_stb` and its `dn_tc_n` driving the upper stage's `dn_stb`, count as an 8-bit value {upper q, lower q}. The pair counts 0 up to 255, wraps to 0, and counts back down to 0.
- R10: While `rst_n` is low, `q` is 0 and both edge registers read idle high. With both strobes high, `up_tc_n` and `dn_tc_n` are then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low system reset |
| up_stb | input | 1 | Up count strobe, idles high |
| dn_stb | input | 1 | Down count strobe, idles high |
| clr | input | 1 | Master clear, active high |
| load_n | input | 1 | Parallel load, active low |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Counter value |
| up_tc_n | output | 1 | Up terminal output, active low |
| dn_tc_n | output | 1 | Down terminal output, active low |

## Verification
The properties assume that every input changes away from the rising clock edge and holds each level for at least one full system cycle. Under that assumption, every strobe phase is seen by at least one sample. They also assume that the previous sample of a strobe means something only from the second cycle after reset. For that reason, a flag gates the count properties for the first cycle. The bench changes all inputs on the falling clock edge and holds each strobe phase for a whole cycle. In single-stage scenarios it lowers only one strobe at a time, except in the test that raises both strobes together on purpose.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_INC   = 3'd3,
    ACT_DEC   = 3'd4
  } udc_act_t;

  localparam int unsigned UDC_NUM_STB = 2;
  localparam int unsigned UDC_IDX_UP  = 0;
  localparam int unsigned UDC_IDX_DN  = 1;

endpackage

// File: rtl/udc_edge_track.sv
module udc_edge_track #(
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic rise
);

  logic stb_q;

  // The previous sample follows the strobe every cycle, clear and load included.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= IDLE_LEVEL;
    end else begin
      stb_q <= stb;
    end
  end

  assign rise = stb & ~stb_q;

endmodule

// File: rtl/udc_action_decode.sv
module udc_action_decode
  import udc_pkg::*;
(
  input  logic     clr,
  input  logic     load_n,
  input  logic     up_stb,
  input  logic     dn_stb,
  input  logic     up_rise,
  input  logic     dn_rise,
  output udc_act_t act
);

  logic up_ok;
  logic dn_ok;

  // A strobe counts only while the other strobe rests high and has not just risen.
  assign up_ok = up_rise & dn_stb & ~dn_rise;
  assign dn_ok = dn_rise & up_stb & ~up_rise;

  always_comb begin
    if (clr) begin
      act = ACT_CLEAR;
    end else if (!load_n) begin
      act = ACT_LOAD;
    end else if (up_ok) begin
      act = ACT_INC;
    end else if (dn_ok) begin
      act = ACT_DEC;
    end else begin
      act = ACT_HOLD;
    end
  end

endmodule

// File: rtl/udc_value_reg.sv
module udc_value_reg
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  udc_act_t         act,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    case (act)
      ACT_CLEAR: q_nxt = '0;
      ACT_LOAD:  q_nxt = din;
      ACT_INC:   q_nxt = q + ONE;
      ACT_DEC:   q_nxt = q - ONE;
      default:   q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/udc_term_detect.sv
module udc_term_detect #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             up_stb,
  input  logic             dn_stb,
  output logic             up_tc_n,
  output logic             dn_tc_n
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  logic at_top;
  logic at_bot;

  assign at_top  = (q == TOP_VAL);
  assign at_bot  = (q == BOT_VAL);
  assign up_tc_n = ~(at_top & ~up_stb);
  assign dn_tc_n = ~(at_bot & ~dn_stb);

endmodule

// File: rtl/udc_counter.sv
module udc_counter
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_stb,
  input  logic             dn_stb,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             up_tc_n,
  output logic             dn_tc_n
);

  logic [UDC_NUM_STB-1:0] stb_vec;
  logic [UDC_NUM_STB-1:0] rise_vec;
  udc_act_t               act;

  assign stb_vec[UDC_IDX_UP] = up_stb;
  assign stb_vec[UDC_IDX_DN] = dn_stb;

  for (genvar g = 0; g < UDC_NUM_STB; g++) begin : g_edge
    udc_edge_track #(.IDLE_LEVEL(1'b1)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (stb_vec[g]),
      .rise  (rise_vec[g])
    );
  end

  udc_action_decode u_dec (
    .clr     (clr),
    .load_n  (load_n),
    .up_stb  (up_stb),
    .dn_stb  (dn_stb),
    .up_rise (rise_vec[UDC_IDX_UP]),
    .dn_rise (rise_vec[UDC_IDX_DN]),
    .act     (act)
  );

  udc_value_reg #(.WIDTH(WIDTH)) u_val (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .din   (din),
    .q     (q)
  );

  udc_term_detect #(.WIDTH(WIDTH)) u_term (
    .q       (q),
    .up_stb  (up_stb),
    .dn_stb  (dn_stb),
    .up_tc_n (up_tc_n),
    .dn_tc_n (dn_tc_n)
  );

endmodule

// File: rtl/udc_counter_chk.sv
module udc_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_stb,
  input logic             dn_stb,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             up_tc_n,
  input logic             dn_tc_n
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: up edge with down resting high increments
  a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr && load_n && up_stb && !$past(up_stb) && dn_stb && $past(dn_stb))
      |=> (q == $past(q) + ONE));

  // R2: down edge with up resting high decrements
  a_r2_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr && load_n && dn_stb && !$past(dn_stb) && up_stb && $past(up_stb))
      |=> (q == $past(q) - ONE));

  // R3: simultaneous edges leave the value alone
  a_r3_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr && load_n && up_stb && !$past(up_stb) && dn_stb && !$past(dn_stb))
      |=> $stable(q));

  // R3: no edge leaves the value alone
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr && load_n && !(up_stb && !$past(up_stb)) && !(dn_stb && !$past(dn_stb)))
      |=> $stable(q));

  // R4: clear wins
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  // R5: load takes the preset
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (q == $past(din)));

  // R6: up terminal low only at the top with the up strobe low
  a_r6_up_tc: assert property (@(posedge clk) disable iff (!rst_n)
    !up_tc_n |-> (q == TOP_VAL && !up_stb));

  // R7: down terminal low only at zero with the down strobe low
  a_r7_dn_tc: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_tc_n |-> (q == '0 && !dn_stb));

endmodule

bind udc_counter udc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .up_stb  (up_stb),
  .dn_stb  (dn_stb),
  .clr     (clr),
  .load_n  (load_n),
  .din     (din),
  .q       (q),
  .up_tc_n (up_tc_n),
  .dn_tc_n (dn_tc_n)
);

// File: tb/udc_counter_tb.sv
module udc_counter_tb;

  localparam int unsigned WIDTH  = 4;
  localparam time         CLK_PD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             up_stb = 1'b1;
  logic             dn_stb = 1'b1;
  logic             clr = 1'b0;
  logic             load_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] q;
  logic             up_tc_n;
  logic             dn_tc_n;

  logic             clr_hi = 1'b0;
  logic             load_n_hi = 1'b1;
  logic [WIDTH-1:0] din_hi = '0;
  logic [WIDTH-1:0] q_hi;
  logic             up_tc_n_hi;
  logic             dn_tc_n_hi;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PD / 2) clk = ~clk;

  udc_counter #(.WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_stb(up_stb), .dn_stb(dn_stb),
    .clr(clr), .load_n(load_n), .din(din),
    .q(q), .up_tc_n(up_tc_n), .dn_tc_n(dn_tc_n)
  );

  udc_counter #(.WIDTH(WIDTH)) u_hi (
    .clk(clk), .rst_n(rst_n), .up_stb(up_tc_n), .dn_stb(dn_tc_n),
    .clr(clr_hi), .load_n(load_n_hi), .din(din_hi),
    .q(q_hi), .up_tc_n(up_tc_n_hi), .dn_tc_n(dn_tc_n_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_load(input int v);
    din = WIDTH'(v); load_n = 1'b0; step(); load_n = 1'b1;
  endtask

  task automatic pulse_up();
    up_stb = 1'b0; step(); up_stb = 1'b1; step();
  endtask

  task automatic pulse_dn();
    dn_stb = 1'b0; step(); dn_stb = 1'b1; step();
  endtask

  task automatic t_reset();
    check("R10 q in reset", int'(q), 0);
    check("R10 up_tc_n in reset", int'(up_tc_n), 1);
    check("R10 dn_tc_n in reset", int'(dn_tc_n), 1);
  endtask

  task automatic t_up_wrap();
    do_load(14);
    check("R5 load 14", int'(q), 14);
    pulse_up(); check("R1 up to 15", int'(q), 15);
    pulse_up(); check("R1 wrap to 0", int'(q), 0);
    step(); step(); check("R3 idle hold", int'(q), 0);
  endtask

  task automatic t_dn_wrap();
    do_load(1);
    pulse_dn(); check("R2 down to 0", int'(q), 0);
    pulse_dn(); check("R2 wrap to 15", int'(q), 15);
  endtask

  task automatic t_term();
    do_load(15);
    #1 check("R6 up_tc_n high with strobe high", int'(up_tc_n), 1);
    up_stb = 1'b0; #1;
    check("R6 up_tc_n low at 15", int'(up_tc_n), 0);
    check("R7 dn_tc_n high at 15", int'(dn_tc_n), 1);
    step(); up_stb = 1'b1; #1;
    check("R6 up_tc_n follows strobe rise", int'(up_tc_n), 1);
    step(); check("R1 wrap after terminal", int'(q), 0);
    dn_stb = 1'b0; #1;
    check("R7 dn_tc_n low at 0", int'(dn_tc_n), 0);
    check("R6 up_tc_n high at 0", int'(up_tc_n), 1);
    step(); dn_stb = 1'b1; #1;
    check("R7 dn_tc_n follows strobe rise", int'(dn_tc_n), 1);
    step(); check("R2 wrap after terminal", int'(q), 15);
    do_load(7);
    dn_stb = 1'b0; #1;
    check("R7 dn_tc_n high at 7", int'(dn_tc_n), 1);
    step(); dn_stb = 1'b1; step();
    check("R2 down from 7", int'(q), 6);
  endtask

  task automatic t_both();
    do_load(9);
    up_stb = 1'b0; dn_stb = 1'b0; step();
    up_stb = 1'b1; dn_stb = 1'b1; step();
    check("R3 both rise hold", int'(q), 9);
  endtask

  task automatic t_clear();
    do_load(11);
    up_stb = 1'b0; step();
    clr = 1'b1; load_n = 1'b0; din = 4'd5; up_stb = 1'b1; step();
    clr = 1'b0; load_n = 1'b1; step();
    check("R4 clear beats load and strobe", int'(q), 0);
  endtask

  task automatic t_load_strobe();
    up_stb = 1'b0; step();
    din = 4'd5; load_n = 1'b0; step();
    up_stb = 1'b1; step();
    check("R5 load ignores strobe rise", int'(q), 5);
    load_n = 1'b1; step();
    check("R5 no late count after load", int'(q), 5);
    up_stb = 1'b0; din = 4'd9; load_n = 1'b0; step(); step();
    load_n = 1'b1; step();
    check("R5 load 9", int'(q), 9);
    up_stb = 1'b1; step();
    check("R8 up counts after load", int'(q), 10);
    dn_stb = 1'b0; clr = 1'b1; step(); step();
    clr = 1'b0; step();
    check("R4 clear", int'(q), 0);
    dn_stb = 1'b1; step();
    check("R8 down counts after clear", int'(q), 15);
  endtask

  task automatic t_chain();
    int exp;
    clr = 1'b1; clr_hi = 1'b1; step();
    clr = 1'b0; clr_hi = 1'b0; step();
    exp = 0;
    check("R9 chain start", int'({q_hi, q}), 0);
    for (int i = 0; i < 255; i++) begin
      pulse_up(); exp = (exp + 1) % 256;
      check("R9 chain up", int'({q_hi, q}), exp);
    end
    pulse_up(); exp = 0;
    check("R9 chain wrap up", int'({q_hi, q}), exp);
    pulse_dn(); exp = 255;
    check("R9 chain wrap down", int'({q_hi, q}), exp);
    for (int i = 0; i < 255; i++) begin
      pulse_dn(); exp = exp - 1;
      check("R9 chain down", int'({q_hi, q}), exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_up_wrap();
    t_dn_wrap();
    t_term();
    t_both();
    t_clear();
    t_load_strobe();
    t_chain();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule